// File: doc/BRIEF.md
# Pad Output Data Register with Atomic Low-Word Commit

This block holds the output values that the management side drives onto 38 pads, and returns the live pad input levels on reads. The pads are split into a 32-bit low word (pads 0 to 31) and a 6-bit high word (pads 32 to 37), both reached from a 32-bit bus with one byte enable per lane. Nothing written can be read back: both read paths always show what the pads present at the moment.

A bus write to the low word is staged. Its enabled byte lanes go into a shadow register. The low 32 outputs change only when a write enables the top lane (lane 3, bits 31:24). That write then moves the shadow, merged with its own bytes, to the outputs in one step, so the low word never shows a half-updated value. The high word has no staging: its 6 bits change together on any high-word write that enables lane 0.

A second, byte-wide port serves a serial debug interface. Its writes take effect on the next clock edge with no staging. Address 0 selects the high word. Addresses 1 to 4 select the low word's bytes from the most significant to the least significant. A debug byte written to the low word also goes into the shadow, so a later staged commit does not undo it.

Top module: `gpio_data_reg`

## Requirements
- R1: Reset drives all 38 outputs and the low-word shadow register to 0. A commit that enables only lane 3 after reset therefore drives bits 23:0 of the low word to 0.
- R2: A bus write to the low word (`bus_sel_hi`=0) with `bus_be[3]`=0 leaves `pad_out` unchanged.
- R3: A bus write to the low word with `bus_be[3]`=1 sets `pad_out[31:0]` one clock edge later. Each enabled lane takes the new bytes. Each disabled lane takes the value held in the shadow.
- R4: A low-word bus write with all four lanes enabled sets `pad_out[31:0]` to `bus_wdata` one edge later. No earlier staging write is needed.
- R5: A bus write to the high word (`bus_sel_hi`=1) with `bus_be[0]`=1 sets all of `pad_out[37:32]` to `bus_wdata[5:0]` one edge later. When `bus_be[0]`=0, the high outputs stay unchanged whatever the other lanes carry.
- R6: `bus_rdata` shows `pad_in[31:0]` when `bus_sel_hi`=0. It shows `pad_in[37:32]` zero-extended when `bus_sel_hi`=1. It never shows values that were written.
- R7: A debug write updates its byte one edge later. Address 0 sets `pad_out[37:32]` from `dbg_wdata[5:0]`. Address k (1 to 4) sets `pad_out` bits [8*(4-k)+7 : 8*(4-k)] and the same shadow byte.
- R8: A debug write to an address from 5 to 7 changes nothing.
- R9: `dbg_rdata` shows the pad input byte that R7's address map selects (address 0 is zero-extended). It shows 0 for addresses 5 to 7.
- R10: When a bus write and a debug write hit the same byte in the same cycle, the bus value wins in both the outputs and the shadow.
- R11: Partial low-word writes build up in the shadow across several writes, until a lane-3 write commits them all at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Bus write strobe |
| bus_sel_hi | input | 1 | Word select: 0 low word, 1 high word |
| bus_be | input | 4 | Bus byte-lane enables |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Live pad inputs for the selected word |
| dbg_wr | input | 1 | Debug byte write strobe |
| dbg_addr | input | 3 | Debug byte address |
| dbg_wdata | input | 8 | Debug write byte |
| dbg_rdata | output | 8 | Live pad input byte at `dbg_addr` |
| pad_in | input | 38 | Pad input levels |
| pad_out | output | 38 | Pad output values |

## Verification
The bench uses the default parameters: a 32-bit low word with four lanes, a 6-bit high word and a 3-bit debug address. This makes every lane combination reachable, including the commit that enables only the top lane. The 3-bit address also leaves three debug addresses with no mapping, so the ignored-write rule can be exercised. The 6-bit high word sits inside a wider lane, which tests both truncation on write and zero-extension on read.

// File: rtl/gpio_data_pkg.sv
`timescale 1ns/1ps
package gpio_data_pkg;

  localparam int BYTE_W = 8;

  // Debug address decode: 0 -> high word (returns lanes),
  // 1..lanes -> low lane (lanes-addr), MSB first; otherwise -1.
  function automatic int dbg_target(input int addr, input int lanes);
    if (addr == 0) return lanes;
    if (addr <= lanes) return lanes - addr;
    return -1;
  endfunction

  // Byte merge for one lane: new byte when enabled, else old.
  function automatic logic [BYTE_W-1:0] lane_pick(input logic en,
                                                  input logic [BYTE_W-1:0] nw,
                                                  input logic [BYTE_W-1:0] old);
    return en ? nw : old;
  endfunction

endpackage

// File: rtl/gpio_lo_stage.sv
`timescale 1ns/1ps
module gpio_lo_stage
  import gpio_data_pkg::*;
#(
  parameter int LO_W = 32
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              bus_wr_lo,
  input  logic [LO_W/BYTE_W-1:0]            bus_be,
  input  logic [LO_W-1:0]                   bus_wdata,
  input  logic                              dbg_lo_wr,
  input  logic [$clog2(LO_W/BYTE_W)-1:0]    dbg_lane,
  input  logic [BYTE_W-1:0]                 dbg_byte,
  output logic                              commit,
  output logic [LO_W-1:0]                   out_lo
);
  localparam int LANES = LO_W / BYTE_W;

  logic [LO_W-1:0] shadow_q, shadow_d, out_d;

  // A write that enables the top lane releases the staged word.
  assign commit = bus_wr_lo & bus_be[LANES-1];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic bus_hit, dbg_hit;
    logic [BYTE_W-1:0] after_dbg_sh, after_dbg_out;
    assign bus_hit = bus_wr_lo & bus_be[g];
    assign dbg_hit = dbg_lo_wr & (int'(dbg_lane) == g);
    assign after_dbg_sh  = lane_pick(dbg_hit, dbg_byte, shadow_q[g*BYTE_W +: BYTE_W]);
    assign after_dbg_out = lane_pick(dbg_hit, dbg_byte, out_lo[g*BYTE_W +: BYTE_W]);
    // bus wins over debug on the same lane
    assign shadow_d[g*BYTE_W +: BYTE_W] =
      lane_pick(bus_hit, bus_wdata[g*BYTE_W +: BYTE_W], after_dbg_sh);
    assign out_d[g*BYTE_W +: BYTE_W] =
      commit ? shadow_d[g*BYTE_W +: BYTE_W] : after_dbg_out;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      out_lo   <= '0;
    end else begin
      shadow_q <= shadow_d;
      out_lo   <= out_d;
    end
  end

endmodule

// File: rtl/gpio_hi_stage.sv
`timescale 1ns/1ps
module gpio_hi_stage
  import gpio_data_pkg::*;
#(
  parameter int HI_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_hi,
  input  logic [HI_W-1:0]   bus_bits,
  input  logic              dbg_hi_wr,
  input  logic [HI_W-1:0]   dbg_bits,
  output logic              hi_load,
  output logic [HI_W-1:0]   out_hi
);
  logic [HI_W-1:0] out_d;

  assign hi_load = bus_wr_hi | dbg_hi_wr;

  always_comb begin
    out_d = out_hi;
    if (dbg_hi_wr) out_d = dbg_bits;
    if (bus_wr_hi) out_d = bus_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_hi <= '0;
    else        out_hi <= out_d;
  end

endmodule

// File: rtl/gpio_rd_mux.sv
`timescale 1ns/1ps
module gpio_rd_mux
  import gpio_data_pkg::*;
#(
  parameter int LO_W = 32,
  parameter int HI_W = 6
) (
  input  logic [LO_W+HI_W-1:0]            pad_in,
  input  logic                            bus_sel_hi,
  input  logic                            dbg_sel_hi,
  input  logic                            dbg_sel_lo,
  input  logic [$clog2(LO_W/BYTE_W)-1:0]  dbg_lane,
  output logic [LO_W-1:0]                 bus_rdata,
  output logic [BYTE_W-1:0]               dbg_rdata
);
  logic [LO_W-1:0]   hi_wide;
  logic [BYTE_W-1:0] hi_byte;

  always_comb begin
    hi_wide = '0;
    hi_wide[HI_W-1:0] = pad_in[LO_W +: HI_W];
    hi_byte = '0;
    hi_byte[HI_W-1:0] = pad_in[LO_W +: HI_W];
  end

  assign bus_rdata = bus_sel_hi ? hi_wide : pad_in[LO_W-1:0];

  always_comb begin
    dbg_rdata = '0;
    if (dbg_sel_hi)      dbg_rdata = hi_byte;
    else if (dbg_sel_lo) dbg_rdata = pad_in[int'(dbg_lane)*BYTE_W +: BYTE_W];
  end

endmodule

// File: rtl/gpio_data_reg.sv
`timescale 1ns/1ps
module gpio_data_reg
  import gpio_data_pkg::*;
#(
  parameter int LO_W   = 32,
  parameter int HI_W   = 6,
  parameter int DBG_AW = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_wr,
  input  logic                   bus_sel_hi,
  input  logic [LO_W/8-1:0]      bus_be,
  input  logic [LO_W-1:0]        bus_wdata,
  output logic [LO_W-1:0]        bus_rdata,
  input  logic                   dbg_wr,
  input  logic [DBG_AW-1:0]      dbg_addr,
  input  logic [7:0]             dbg_wdata,
  output logic [7:0]             dbg_rdata,
  input  logic [LO_W+HI_W-1:0]   pad_in,
  output logic [LO_W+HI_W-1:0]   pad_out
);
  localparam int LANES   = LO_W / BYTE_W;
  localparam int LANE_IW = $clog2(LANES);

  // named internal events (observed by the bound checker)
  int                 dbg_tgt;
  logic               dbg_sel_hi, dbg_sel_lo;
  logic [LANE_IW-1:0] dbg_lane;
  logic               bus_wr_lo, bus_wr_hi;
  logic               lo_commit, hi_load;
  logic [LO_W-1:0]    out_lo;
  logic [HI_W-1:0]    out_hi;

  assign dbg_tgt    = dbg_target(int'(dbg_addr), LANES);
  assign dbg_sel_hi = (dbg_tgt == LANES);
  assign dbg_sel_lo = (dbg_tgt >= 0) && (dbg_tgt < LANES);
  assign dbg_lane   = dbg_tgt[LANE_IW-1:0];
  assign bus_wr_lo  = bus_wr & ~bus_sel_hi;
  assign bus_wr_hi  = bus_wr & bus_sel_hi & bus_be[0];

  gpio_lo_stage #(.LO_W(LO_W)) u_lo (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr_lo (bus_wr_lo),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .dbg_lo_wr (dbg_wr & dbg_sel_lo),
    .dbg_lane  (dbg_lane),
    .dbg_byte  (dbg_wdata),
    .commit    (lo_commit),
    .out_lo    (out_lo)
  );

  gpio_hi_stage #(.HI_W(HI_W)) u_hi (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr_hi (bus_wr_hi),
    .bus_bits  (bus_wdata[HI_W-1:0]),
    .dbg_hi_wr (dbg_wr & dbg_sel_hi),
    .dbg_bits  (dbg_wdata[HI_W-1:0]),
    .hi_load   (hi_load),
    .out_hi    (out_hi)
  );

  gpio_rd_mux #(.LO_W(LO_W), .HI_W(HI_W)) u_rd (
    .pad_in     (pad_in),
    .bus_sel_hi (bus_sel_hi),
    .dbg_sel_hi (dbg_sel_hi),
    .dbg_sel_lo (dbg_sel_lo),
    .dbg_lane   (dbg_lane),
    .bus_rdata  (bus_rdata),
    .dbg_rdata  (dbg_rdata)
  );

  assign pad_out = {out_hi, out_lo};

endmodule

// File: rtl/gpio_data_reg_chk.sv
`timescale 1ns/1ps
module gpio_data_reg_chk #(
  parameter int LO_W   = 32,
  parameter int HI_W   = 6,
  parameter int DBG_AW = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_wr,
  input logic                  bus_sel_hi,
  input logic [LO_W/8-1:0]     bus_be,
  input logic [LO_W-1:0]       bus_wdata,
  input logic [LO_W-1:0]       bus_rdata,
  input logic                  dbg_wr,
  input logic [DBG_AW-1:0]     dbg_addr,
  input logic [LO_W+HI_W-1:0]  pad_in,
  input logic [LO_W+HI_W-1:0]  pad_out,
  input logic                  lo_commit,
  input logic                  hi_load
);
  localparam int LANES = LO_W / 8;

  // R1: outputs are clear on the first edge after reset release
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> pad_out == '0);

  // R2: a staging-only low write keeps the low outputs
  a_r2_partial_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_sel_hi && !bus_be[LANES-1] && !dbg_wr) |=> $stable(pad_out[LO_W-1:0]));

  // R3: top-lane write puts its top byte on the outputs
  a_r3_top_lane: assert property (@(posedge clk) disable iff (!rst_n)
    lo_commit |=> pad_out[LO_W-1 -: 8] == $past(bus_wdata[LO_W-1 -: 8]));

  // R5: no high-word source, no change on high outputs
  a_r5_hi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_load |=> $stable(pad_out[LO_W +: HI_W]));

  // R5: high write with lane 0 loads all high bits
  a_r5_hi_load: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_sel_hi && bus_be[0]) |=> pad_out[LO_W +: HI_W] == $past(bus_wdata[HI_W-1:0]));

  // R8: unmapped debug address changes nothing
  a_r8_bad_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_wr && int'(dbg_addr) > LANES && !bus_wr) |=> $stable(pad_out));

  // R6: low read is the live pad inputs
  always_comb begin
    if (rst_n && !bus_sel_hi)
      a_r6_live_read: assert (bus_rdata == pad_in[LO_W-1:0]);
  end

endmodule

bind gpio_data_reg gpio_data_reg_chk #(.LO_W(LO_W), .HI_W(HI_W), .DBG_AW(DBG_AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .bus_sel_hi (bus_sel_hi),
  .bus_be     (bus_be),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .dbg_wr     (dbg_wr),
  .dbg_addr   (dbg_addr),
  .pad_in     (pad_in),
  .pad_out    (pad_out),
  .lo_commit  (lo_commit),
  .hi_load    (hi_load)
);

// File: tb/tb_gpio_data_reg.sv
`timescale 1ns/1ps
module tb_gpio_data_reg;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_sel_hi = 1'b0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        dbg_wr = 1'b0;
  logic [2:0]  dbg_addr = '0;
  logic [7:0]  dbg_wdata = '0;
  logic [7:0]  dbg_rdata;
  logic [37:0] pad_in = '0;
  logic [37:0] pad_out;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_data_reg dut (.*);

  // kind: 0 bus low word, 1 bus high word, 2 debug byte
  typedef struct packed {
    logic [1:0]  kind;
    logic [2:0]  addr;
    logic [3:0]  be;
    logic [31:0] data;
    logic [37:0] exp;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 3'd0, 4'b0011, 32'h0000BEEF, 38'h0000000000},  // R2
    '{2'd0, 3'd0, 4'b0100, 32'h00AA0000, 38'h0000000000},  // R11
    '{2'd0, 3'd0, 4'b1000, 32'h55000000, 38'h0055AABEEF},  // R3
    '{2'd1, 3'd0, 4'b0001, 32'h0000002A, 38'h2A55AABEEF},  // R5
    '{2'd1, 3'd0, 4'b1110, 32'hFFFFFF3F, 38'h2A55AABEEF},  // R5 ignore
    '{2'd0, 3'd0, 4'b1111, 32'h12345678, 38'h2A12345678},  // R4
    '{2'd2, 3'd4, 4'b0000, 32'h000000C3, 38'h2A123456C3},  // R7
    '{2'd2, 3'd0, 4'b0000, 32'h000000FF, 38'h3F123456C3},  // R7
    '{2'd2, 3'd1, 4'b0000, 32'h0000009A, 38'h3F9A3456C3},  // R7
    '{2'd2, 3'd5, 4'b0000, 32'h00000000, 38'h3F9A3456C3},  // R8
    '{2'd2, 3'd7, 4'b0000, 32'h00000000, 38'h3F9A3456C3},  // R8
    '{2'd0, 3'd0, 4'b0001, 32'h00000011, 38'h3F9A3456C3},  // R2
    '{2'd0, 3'd0, 4'b1000, 32'h01000000, 38'h3F01345611}   // R7 shadow, R3
  };

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(int kind, logic [2:0] a, logic [3:0] be, logic [31:0] d);
    @(negedge clk);
    if (kind == 2) begin
      dbg_wr = 1'b1; dbg_addr = a; dbg_wdata = d[7:0];
    end else begin
      bus_wr = 1'b1; bus_sel_hi = (kind == 1); bus_be = be; bus_wdata = d;
    end
    @(negedge clk);
    bus_wr = 1'b0; dbg_wr = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset outputs", 64'(pad_out), 64'h0);

    for (int i = 0; i < NV; i++) begin
      drive(int'(VECS[i].kind), VECS[i].addr, VECS[i].be, VECS[i].data);
      check($sformatf("R2/R3/R4/R5/R7/R8/R11 vec %0d", i), 64'(pad_out), 64'(VECS[i].exp));
    end

    // R6 / R9: reads show live pad inputs, not stored outputs
    pad_in = 38'h15_C0FFEE42;
    bus_sel_hi = 1'b0; #1;
    check("R6 low read", 64'(bus_rdata), 64'hC0FFEE42);
    bus_sel_hi = 1'b1; #1;
    check("R6 high read", 64'(bus_rdata), 64'h15);
    bus_sel_hi = 1'b0;
    for (int a = 0; a < 8; a++) begin
      logic [7:0] e;
      dbg_addr = 3'(a); #1;
      case (a)
        0: e = 8'h15;
        1: e = 8'hC0;
        2: e = 8'hFF;
        3: e = 8'hEE;
        4: e = 8'h42;
        default: e = 8'h00;
      endcase
      check($sformatf("R9 debug read addr %0d", a), 64'(dbg_rdata), 64'(e));
    end

    // R10: same-cycle collision, bus wins
    @(negedge clk);
    bus_wr = 1'b1; bus_sel_hi = 1'b0; bus_be = 4'b1111; bus_wdata = 32'hAAAAAAAA;
    dbg_wr = 1'b1; dbg_addr = 3'd4; dbg_wdata = 8'h55;
    @(negedge clk);
    bus_wr = 1'b0; dbg_wr = 1'b0;
    check("R10 low collision", 64'(pad_out[31:0]), 64'hAAAAAAAA);
    @(negedge clk);
    bus_wr = 1'b1; bus_sel_hi = 1'b1; bus_be = 4'b0001; bus_wdata = 32'h00000005;
    dbg_wr = 1'b1; dbg_addr = 3'd0; dbg_wdata = 8'h3A;
    @(negedge clk);
    bus_wr = 1'b0; dbg_wr = 1'b0; bus_sel_hi = 1'b0;
    check("R10 high collision", 64'(pad_out[37:32]), 64'h05);

    // R1: shadow cleared by reset
    drive(0, 3'd0, 4'b0011, 32'h0000FFFF);
    do_reset();
    check("R1 outputs after mid-run reset", 64'(pad_out), 64'h0);
    drive(0, 3'd0, 4'b1000, 32'h80000000);
    check("R1 shadow cleared", 64'(pad_out), 64'h0080000000);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule